// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns words from a one-entry holding register into asynchronous serial frames. Each frame has a low start bit, eight or nine data bits sent least significant first, an optional parity bit and a high stop bit. The bit timing comes from a baud strobe that is generated outside the block, and every frame state lasts from one strobe to the next. The block does not generate the baud rate, receive data, or hold a software register file.

Around that core it offers several options. A new transfer that starts from idle can wait zero to three baud periods first, while frames that follow each other directly get no such wait. The pad can be tristated automatically while nothing is being sent. In smart-card operation, a frame that the far end rejects can be sent again. Error pulses from the companion receiver can switch the transmitter off, and only a software enable pulse turns it back on. A free-running mode also exists, in which the block sends whenever the receive side has room and flags an underflow when it has no data.

Top module: `sertx`

## Requirements
- R1: After reset the transmitter is disabled, the holding register is empty, the line rests at its idle level (high with `cfg_inv`=0), `tx_idle` is 1, `underflow` is 0, and `tx_tri` is 0 while `cfg_auto_tri` is 0.
- R2: A frame is sent as a low start bit, then the data bits with bit 0 first (8 bits, or 9 when `cfg_nine`=1), then the optional parity bit, then a high stop bit. Each bit lasts exactly one baud strobe interval.
- R3: When `cfg_par_en`=1, the parity bit is the XOR of all transmitted data bits, inverted when `cfg_par_odd`=1.
- R4: A write with `wr_nine`=1 stores `wr_data[8]` as the ninth bit. A write with `wr_nine`=0 stores `cfg_bit8_dflt` in that position.
- R5: A frame that starts from idle begins `cfg_delay` baud strobes after the strobe that accepts it. The start bit therefore appears on strobe number `cfg_delay`+1 after the write.
- R6: When the holding register is full at the strobe that ends a stop bit (or that ends an accepted guard period), the next start bit follows on that same strobe, whatever the value of `cfg_delay`.
- R7: With `cfg_auto_tri`=1, `tx_tri` is 1 while the transmitter is idle or waiting out a delay, and 0 from the start bit until the frame ends. With `cfg_auto_tri`=0, `tx_tri` stays 0 and the idle line level is the inverse of `cfg_inv`.
- R8: With `cfg_sc_mode`=1, one guard period follows each stop bit. If `line_in` is low at the strobe that ends the guard period and `cfg_sc_retx`=1, the same frame starts again on that strobe. If `cfg_sc_retx`=0, the frame is dropped and the block goes idle.
- R9: With `cfg_err_off`=1, a pulse on `rx_frame_err` or `rx_parity_err` clears the enable and aborts any frame in the next cycle, leaving the line idle. With `cfg_err_off`=0, these pulses have no effect.
- R10: While disabled, the block starts no frame and a buffered word is kept. An `en_pulse` enables the block.
- R11: With `cfg_always_tx`=1, frames start only while `rx_full`=0. At each strobe where the block is enabled, idle, `rx_full`=0 and the holding register is empty, `underflow` pulses for one cycle.
- R12: A write that arrives while the holding register is full, and is not being consumed in that cycle, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle baud strobe |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_nine | input | 1 | 1: write carries the ninth bit |
| wr_data | input | 9 | Write data |
| cfg_nine | input | 1 | 1: nine data bits per frame |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Odd parity select |
| cfg_bit8_dflt | input | 1 | Ninth bit used for 8-bit writes |
| cfg_delay | input | 2 | Baud periods to wait before a frame that starts from idle |
| cfg_auto_tri | input | 1 | Tristate the pad while idle |
| cfg_inv | input | 1 | Invert the line output |
| cfg_sc_mode | input | 1 | Smart-card guard period enable |
| cfg_sc_retx | input | 1 | Resend frames that are rejected |
| cfg_err_off | input | 1 | Receiver errors switch the block off |
| cfg_always_tx | input | 1 | Free-running transmit mode |
| en_pulse | input | 1 | Enable the transmitter |
| rx_frame_err | input | 1 | Framing error pulse from the receiver |
| rx_parity_err | input | 1 | Parity error pulse from the receiver |
| rx_full | input | 1 | Receive buffer full |
| line_in | input | 1 | Line level seen during the guard period |
| tx_out | output | 1 | Serial output |
| tx_tri | output | 1 | Pad tristate enable |
| underflow | output | 1 | Underflow pulse |
| tx_idle | output | 1 | No frame in progress |
| tx_enabled | output | 1 | Transmitter enabled |
| hold_full | output | 1 | Holding register occupied |

## Verification
The assertions assume that `baud_tick` is a single-cycle strobe with at least one quiet cycle between strobes, and that configuration inputs change only while the block is idle. The stimulus follows both rules. The bench raises its strobe once every four clocks, and it changes settings only after the block has returned to idle. Random frames vary the data, the ninth-bit source, the parity, the frame width and the delay. Directed cases then exercise back-to-back frames, guard-period rejection, error shutdown, and the free-running mode.

// File: rtl/sertx.sv
module sertx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       wr_valid,
  input  logic       wr_nine,
  input  logic [8:0] wr_data,
  input  logic       cfg_nine,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_bit8_dflt,
  input  logic [1:0] cfg_delay,
  input  logic       cfg_auto_tri,
  input  logic       cfg_inv,
  input  logic       cfg_sc_mode,
  input  logic       cfg_sc_retx,
  input  logic       cfg_err_off,
  input  logic       cfg_always_tx,
  input  logic       en_pulse,
  input  logic       rx_frame_err,
  input  logic       rx_parity_err,
  input  logic       rx_full,
  input  logic       line_in,
  output logic       tx_out,
  output logic       tx_tri,
  output logic       underflow,
  output logic       tx_idle,
  output logic       tx_enabled,
  output logic       hold_full
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_START, S_DATA, S_PAR, S_STOP, S_GUARD} st_t;

  st_t        st;
  logic [8:0] hold_q, frm;
  logic       hold_v, en_q, uflow_q, raw;
  logic [3:0] idx;
  logic [1:0] dcnt;

  wire err_kill  = cfg_err_off & (rx_frame_err | rx_parity_err);
  wire room      = !cfg_always_tx || !rx_full;
  wire ready     = en_q && hold_v && room;
  wire [3:0] last_idx = cfg_nine ? 4'd8 : 4'd7;
  wire par_bit   = ^(cfg_nine ? frm : {1'b0, frm[7:0]}) ^ cfg_par_odd;
  wire stop_done = (st == S_STOP && !cfg_sc_mode) || (st == S_GUARD && line_in);
  wire load      = baud_tick && !err_kill && ready && (st == S_IDLE || stop_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_q <= '0;
    end else begin
      if (load) hold_v <= 1'b0;
      if (wr_valid && (!hold_v || load)) begin
        hold_v <= 1'b1;
        hold_q <= {wr_nine ? wr_data[8] : cfg_bit8_dflt, wr_data[7:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      en_q    <= 1'b0;
      uflow_q <= 1'b0;
      frm     <= '0;
      idx     <= '0;
      dcnt    <= '0;
    end else begin
      uflow_q <= 1'b0;
      if (en_pulse) en_q <= 1'b1;
      if (err_kill) en_q <= 1'b0;
      if (err_kill) st <= S_IDLE;
      else if (baud_tick) begin
        if (load) frm <= hold_q;
        case (st)
          S_IDLE: begin
            if (load) begin
              st   <= (cfg_delay == 2'd0) ? S_START : S_WAIT;
              dcnt <= cfg_delay - 2'd1;
            end else if (en_q && cfg_always_tx && !rx_full && !hold_v) begin
              uflow_q <= 1'b1;
            end
          end
          S_WAIT:  if (dcnt == 2'd0) st <= S_START; else dcnt <= dcnt - 2'd1;
          S_START: begin st <= S_DATA; idx <= '0; end
          S_DATA:  if (idx == last_idx) st <= cfg_par_en ? S_PAR : S_STOP;
                   else idx <= idx + 4'd1;
          S_PAR:   st <= S_STOP;
          default: begin
            if (st == S_STOP && cfg_sc_mode) st <= S_GUARD;
            else if (st == S_GUARD && !line_in) st <= cfg_sc_retx ? S_START : S_IDLE;
            else if (load) st <= S_START;
            else st <= S_IDLE;
          end
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      S_START: raw = 1'b0;
      S_DATA:  raw = frm[idx];
      S_PAR:   raw = par_bit;
      default: raw = 1'b1;
    endcase
  end

  assign tx_out     = raw ^ cfg_inv;
  assign tx_idle    = (st == S_IDLE) || (st == S_WAIT);
  assign tx_tri     = cfg_auto_tri && tx_idle;
  assign underflow  = uflow_q;
  assign tx_enabled = en_q;
  assign hold_full  = hold_v;

  assert_hold_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v && wr_valid && !load |=> $stable(hold_q));

  assert_err_disables_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_kill |=> !tx_enabled && tx_idle);

  assert_state_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick && !err_kill |=> $stable(st));

  assert_start_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_idle) |-> $past(baud_tick));

  assert_uflow_on_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(baud_tick) && tx_idle);

  assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enabled && tx_idle |=> tx_idle);

endmodule

// File: tb/sertx_tb.sv
`timescale 1ns/1ps
module sertx_tb;
  logic clk = 0, rst_n = 0, baud_tick = 0;
  logic wr_valid = 0, wr_nine = 0;
  logic [8:0] wr_data = '0;
  logic cfg_nine = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_bit8_dflt = 0;
  logic [1:0] cfg_delay = 0;
  logic cfg_auto_tri = 0, cfg_inv = 0, cfg_sc_mode = 0, cfg_sc_retx = 0;
  logic cfg_err_off = 0, cfg_always_tx = 0, en_pulse = 0;
  logic rx_frame_err = 0, rx_parity_err = 0, rx_full = 0, line_in = 1;
  logic tx_out, tx_tri, underflow, tx_idle, tx_enabled, hold_full;
  int checks = 0, errors = 0, tcnt = 0;

  sertx u_dut (.*);

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt      <= (tcnt == 3) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == 3);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_word(input logic [8:0] d, input logic n9,
                                          input logic w9, input logic dflt);
    logic b8 = w9 ? d[8] : dflt;
    return n9 ? {b8, d[7:0]} : {1'b0, d[7:0]};
  endfunction

  function automatic logic exp_par(input logic [8:0] w, input logic odd);
    return ^w ^ odd;
  endfunction

  task automatic wait_tick();
    @(posedge clk);
    while (!baud_tick) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] d, input logic n9);
    wr_valid = 1; wr_data = d; wr_nine = n9;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic pulse_en();
    en_pulse = 1; @(negedge clk); en_pulse = 0;
  endtask

  task automatic cap(output logic [8:0] d, output logic p, output logic s, output int lead);
    d = '0; p = 0; s = 0; lead = 0;
    do begin wait_tick(); lead++; end while (tx_out != 1'b0 && lead < 40);
    for (int i = 0; i < (cfg_nine ? 9 : 8); i++) begin wait_tick(); d[i] = tx_out; end
    if (cfg_par_en) begin wait_tick(); p = tx_out; end
    wait_tick(); s = tx_out;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] d, e;
    logic p, s, w9;
    int lead;
    void'($urandom(32'hBEEF));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_out", tx_out, 1);
    chk("R1 tx_tri", tx_tri, 0);
    chk("R1 tx_idle", tx_idle, 1);
    chk("R1 underflow", underflow, 0);
    chk("R1 tx_enabled", tx_enabled, 0);
    chk("R1 hold_full", hold_full, 0);

    // R10 disabled holds data, R12 second write dropped
    wr(9'h05A, 0);
    wr(9'h033, 0);
    repeat (5) begin wait_tick(); chk("R10 idle while disabled", tx_idle, 1); end
    chk("R10 word kept", hold_full, 1);
    pulse_en();
    chk("R10 enabled", tx_enabled, 1);
    cap(d, p, s, lead);
    chk("R12 first word kept", d, 9'h05A);
    chk("R2 stop bit", s, 1);
    wait_tick();

    // R5 delay and R7 auto tristate
    cfg_auto_tri = 1;
    for (int k = 0; k < 4; k++) begin
      cfg_delay = k[1:0];
      @(negedge clk);
      chk("R7 tri when idle", tx_tri, 1);
      wr(9'h0C3 + 9'(k), 0);
      cap(d, p, s, lead);
      chk("R5 lead ticks", lead, k + 1);
      chk("R7 tri released in frame", tx_tri, 0);
      chk("R2 data", d, 9'h0C3 + 9'(k));
      wait_tick();
    end
    cfg_auto_tri = 0;

    // R6 back-to-back ignores delay
    cfg_delay = 3;
    wr(9'h011, 0);
    wait_tick();
    wr(9'h0EE, 0);
    cap(d, p, s, lead);
    chk("R6 first lead", lead, 3);
    chk("R6 first data", d, 9'h011);
    cap(d, p, s, lead);
    chk("R6 back-to-back lead", lead, 1);
    chk("R6 second data", d, 9'h0EE);
    wait_tick();

    // R4 directed default ninth bit
    cfg_nine = 1; cfg_delay = 0;
    cfg_bit8_dflt = 1; wr(9'h012, 0); cap(d, p, s, lead);
    chk("R4 default bit8=1", d, 9'h112); wait_tick();
    cfg_bit8_dflt = 0; wr(9'h112, 0); cap(d, p, s, lead);
    chk("R4 default bit8=0", d, 9'h012); wait_tick();
    wr(9'h112, 1); cap(d, p, s, lead);
    chk("R4 written bit8", d, 9'h112); wait_tick();

    // R2 R3 R4 R5 random frames
    for (int n = 0; n < 40; n++) begin
      cfg_nine = 1'($urandom); cfg_par_en = 1'($urandom); cfg_par_odd = 1'($urandom);
      cfg_bit8_dflt = 1'($urandom); cfg_delay = 2'($urandom);
      d = 9'($urandom); w9 = 1'($urandom);
      e = exp_word(d, cfg_nine, w9, cfg_bit8_dflt);
      @(negedge clk);
      wr(d, w9);
      cap(d, p, s, lead);
      chk("R2 R4 random data", d, e);
      if (cfg_par_en) chk("R3 parity", p, exp_par(e, cfg_par_odd));
      chk("R2 random stop", s, 1);
      chk("R5 random lead", lead, cfg_delay + 1);
      wait_tick();
    end
    cfg_nine = 0; cfg_par_en = 0; cfg_par_odd = 0; cfg_delay = 0;

    // R7 inverted idle level without auto tristate
    cfg_inv = 1; @(negedge clk);
    chk("R7 inverted idle", tx_out, 0);
    chk("R7 no tri", tx_tri, 0);
    cfg_inv = 0; @(negedge clk);

    // R8 smart card retransmit
    cfg_sc_mode = 1; cfg_sc_retx = 1; cfg_par_en = 1;
    wr(9'h0A5, 0);
    cap(d, p, s, lead);
    wait_tick();
    chk("R8 guard level", tx_out, 1);
    line_in = 0;
    cap(d, p, s, lead);
    line_in = 1;
    chk("R8 resend lead", lead, 1);
    chk("R8 resend data", d, 9'h0A5);
    chk("R8 resend parity", p, exp_par(9'h0A5, 0));
    wait_tick(); wait_tick();
    chk("R8 idle after accept", tx_idle, 1);
    cfg_sc_retx = 0;
    wr(9'h03C, 0);
    cap(d, p, s, lead);
    wait_tick();
    line_in = 0;
    wait_tick();
    line_in = 1;
    chk("R8 no resend when off", tx_idle, 1);
    wait_tick();
    chk("R8 still idle", tx_out, 1);
    cfg_sc_mode = 0; cfg_par_en = 0;

    // R9 error shutdown
    cfg_err_off = 1;
    wr(9'h0F0, 0);
    wait_tick();
    chk("R9 frame started", tx_out, 0);
    rx_parity_err = 1; @(negedge clk); rx_parity_err = 0;
    chk("R9 aborted idle", tx_idle, 1);
    chk("R9 line idle", tx_out, 1);
    chk("R9 disabled", tx_enabled, 0);
    wr(9'h07E, 0);
    repeat (4) wait_tick();
    chk("R9 stays off", tx_idle, 1);
    pulse_en();
    cap(d, p, s, lead);
    chk("R9 resume data", d, 9'h07E);
    wait_tick();
    cfg_err_off = 0;
    wr(9'h099, 0);
    rx_frame_err = 1; @(negedge clk); rx_frame_err = 0;
    cap(d, p, s, lead);
    chk("R9 ignored error data", d, 9'h099);
    chk("R9 ignored error enable", tx_enabled, 1);
    wait_tick();

    // R11 always-transmit
    cfg_always_tx = 1;
    wait_tick();
    chk("R11 underflow", underflow, 1);
    chk("R11 idle on underflow", tx_idle, 1);
    rx_full = 1;
    wait_tick();
    chk("R11 no underflow when full", underflow, 0);
    wr(9'h066, 0);
    repeat (3) wait_tick();
    chk("R11 held while rx full", tx_idle, 1);
    rx_full = 0;
    cap(d, p, s, lead);
    chk("R11 lead", lead, 1);
    chk("R11 data", d, 9'h066);
    cfg_always_tx = 0;
    wait_tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule